// File: doc/BRIEF.md
# Frame Writeback Sequencer

This block drives a display writeback path. An upstream compositor hands it finished pixels one line at a time, and the block writes them into a linear raster buffer in memory. Software sets a destination base, a line pitch and the frame size through a small 32-bit register bus. It then sets a start bit. The sequencer steps through the frame and works out the destination address of every pixel. It issues one write per pixel on a simple request/acknowledge write port. It counts each line as committed once the memory side has acknowledged the last write of that line.

When the frame ends the block goes idle. If the idle interrupt is enabled it raises an interrupt that stays up until software writes the control word with the enable bit cleared. Software can abort a frame at once, can hold the engine in a powered-down state that refuses to start, and can ask for a second frame-start request to the compositor at end of frame. Pixel format conversion, tiling and rotation are not part of this block; pixels pass through unchanged, four bytes each.

Top module: `wb_frame_seq`

## Requirements
- R1: After reset the control word reads 0x5440_0000, base, pitch, dimension and progress read 0, and `wr_req`, `frame_req` and `irq` are low.
- R2: Control bits 31:24 always read 0x54 and bits 23:22 always read 0x1, whatever was written. The start bit (bit 0) and the abort bit (bit 14) read 0. Bits 2..13 and 15..21 read back as written. Bit 1 reads the busy state.
- R3: Register offsets are base 0x00, pitch 0x04, dimension 0x08, control 0x0C and progress 0x10. Base bits 1:0 and pitch bits 3:0 are dropped and read 0. The dimension word holds height in bits 31:16 and width in bits 15:0.
- R4: A control write with bit 0 set, taken while idle and powered up, starts a frame. Busy (bit 1) then reads 1, and `frame_req` pulses high for the single cycle after the write edge.
- R5: Pixel x of line y goes to base + y·pitch + 4·x. Pixels are written in raster order, one write each. Each request holds its address and data stable until it is acknowledged.
- R6: The progress register is cleared at frame start. It counts a line only after the acknowledge of that line's last write.
- R7: After the last line is committed the block returns to idle and busy reads 0.
- R8: When a frame ends with control bit 2 set, `irq` rises and stays high. A control write with bit 2 clear drops it. A frame that ends with bit 2 clear raises no interrupt.
- R9: A control write with bit 14 set, made during a frame, ends the frame at once. Busy and `wr_req` are low from the next cycle, and no further write, commit or end-of-frame start request follows. An abort in the same cycle as the acknowledge of a line's last write wins: that line is not counted.
- R10: While control bit 21 is set, or when it is set in the start write itself, a start is ignored: no writes, no `frame_req`, and progress keeps its value.
- R11: A start bit written during a frame is ignored. The frame carries on with all its writes, and progress is not cleared.
- R12: A start with height 0 or width 0 ends the frame at once. It makes no writes and no `frame_req`, clears progress, and raises the interrupt if bit 2 is set.
- R13: If control bit 15 is set, `frame_req` pulses again in the cycle after the edge that commits the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data follows one cycle later |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| pix_valid | input | 1 | Upstream pixel available |
| pix_data | input | PIX_W | Upstream pixel value |
| pix_ready | output | 1 | Sequencer takes a pixel this cycle |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | PIX_W | Write data |
| wr_ack | input | 1 | Memory side accepts the pending write |
| frame_req | output | 1 | One-cycle frame-start request to the compositor |
| irq | output | 1 | Idle interrupt |

## Verification
The sharpest collision is a software abort landing on the very edge where memory acknowledges the final write of a line. The bench provokes it by holding back the acknowledge until the last pixel's request is up. It then raises the acknowledge and the abort control write in the same cycle. It judges the result at the ports: progress must still show the line as uncommitted, the end-of-frame start request must not appear even though bit 15 is set, and busy must read 0. A second overlap, a start write arriving mid-frame while writes are stalled, is judged by the full write count and the uncleared progress.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int REG_W  = 32;
  localparam int DIM_W  = 16;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 5;

  localparam logic [OFS_W-1:0] OFS_BASE  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_PITCH = 5'h04;
  localparam logic [OFS_W-1:0] OFS_DIM   = 5'h08;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_PROG  = 5'h10;

  localparam int CB_GO    = 0;
  localparam int CB_BUSY  = 1;
  localparam int CB_IE    = 2;
  localparam int CB_ABORT = 14;
  localparam int CB_REGEN = 15;
  localparam int CB_PDN   = 21;

  localparam logic [REG_W-1:0] CTRL_ID    = 32'h5440_0000;
  localparam logic [REG_W-1:0] CTRL_KEEP  = 32'h003F_BFFC;
  localparam logic [REG_W-1:0] BASE_MASK  = 32'hFFFF_FFFC;
  localparam logic [REG_W-1:0] PITCH_MASK = 32'hFFFF_FFF0;

  typedef enum logic [1:0] {ST_IDLE, ST_TAKE, ST_PUT} eng_state_t;
endpackage

// File: rtl/wbs_regs.sv
module wbs_regs
  import wbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              busy_i,
  input  logic              frame_end_i,
  input  logic [DIM_W-1:0]  progress_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] pitch_o,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output logic              regen_o,
  output logic              go_o,
  output logic              abort_o,
  output logic              irq_o
);
  logic [REG_W-1:0] base_q, pitch_q, dim_q, ctrl_q, rdata_q;
  logic             irq_q;
  logic             ctrl_wr, ie_eff;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  // abort and power-down in the same write both veto the start
  assign go_o    = ctrl_wr && bus_wdata[CB_GO] && !bus_wdata[CB_ABORT] && !bus_wdata[CB_PDN];
  assign abort_o = ctrl_wr && bus_wdata[CB_ABORT];
  assign ie_eff  = ctrl_wr ? bus_wdata[CB_IE] : ctrl_q[CB_IE];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      pitch_q <= '0;
      dim_q   <= '0;
      ctrl_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_BASE:  base_q  <= bus_wdata & BASE_MASK;
        OFS_PITCH: pitch_q <= bus_wdata & PITCH_MASK;
        OFS_DIM:   dim_q   <= bus_wdata;
        OFS_CTRL:  ctrl_q  <= bus_wdata & CTRL_KEEP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               irq_q <= 1'b0;
    else if (ctrl_wr && !bus_wdata[CB_IE]) irq_q <= 1'b0;
    else if (frame_end_i && ie_eff)        irq_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      rdata_q <= '0;
      case (bus_addr)
        OFS_BASE:  rdata_q <= base_q;
        OFS_PITCH: rdata_q <= pitch_q;
        OFS_DIM:   rdata_q <= dim_q;
        OFS_CTRL:  begin
          rdata_q          <= CTRL_ID | ctrl_q;
          rdata_q[CB_BUSY] <= busy_i;
        end
        OFS_PROG:  rdata_q[DIM_W-1:0] <= progress_i;
        default: ;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign base_o    = base_q;
  assign pitch_o   = pitch_q;
  assign width_o   = dim_q[DIM_W-1:0];
  assign height_o  = dim_q[16 +: DIM_W];
  assign regen_o   = ctrl_q[CB_REGEN];
  assign irq_o     = irq_q;

  // R8: a raised interrupt implies the enable bit is held
  a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ctrl_q[CB_IE]);
  // R10: a start written together with power-down leaves the engine idle
  a_r10_pdn_blocks: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[CB_GO] && bus_wdata[CB_PDN] && !busy_i) |=> !busy_i);
endmodule

// File: rtl/wbs_addr.sv
module wbs_addr
  import wbs_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              line_done_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] pitch_i,
  input  logic [DIM_W-1:0]  col_i,
  output logic [ADDR_W-1:0] pix_addr_o
);
  localparam int PIX_BYTES = PIX_W / 8;
  localparam int PIX_SH    = $clog2(PIX_BYTES);

  logic [ADDR_W-1:0] line_q;

  // running line base: one adder instead of a row-by-pitch multiplier
  always_ff @(posedge clk) begin
    if (rst)              line_q <= '0;
    else if (start_i)     line_q <= base_i;
    else if (line_done_i) line_q <= line_q + pitch_i;
  end

  assign pix_addr_o = line_q + (ADDR_W'(col_i) << PIX_SH);
endmodule

// File: rtl/wbs_engine.sv
module wbs_engine
  import wbs_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              abort_i,
  input  logic              regen_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [ADDR_W-1:0] pix_addr_i,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              wr_ack,
  output logic              pix_ready,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data,
  output logic              frame_req,
  output logic              busy_o,
  output logic              start_o,
  output logic              line_done_o,
  output logic              frame_end_o,
  output logic [DIM_W-1:0]  col_o,
  output logic [DIM_W-1:0]  progress_o
);
  eng_state_t        state_q;
  logic [DIM_W-1:0]  col_q, prog_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PIX_W-1:0]  data_q;
  logic              freq_q;
  logic              busy, start, empty, last_col, last_row, commit, line_done;

  assign busy      = (state_q != ST_IDLE);
  assign start     = go_i && !busy;
  assign empty     = (width_i == '0) || (height_i == '0);
  assign last_col  = (col_q == width_i - DIM_W'(1));
  // committed-line count doubles as the row index
  assign last_row  = (prog_q == height_i - DIM_W'(1));
  assign commit    = (state_q == ST_PUT) && wr_ack && !abort_i;
  assign line_done = commit && last_col;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      prog_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      freq_q  <= 1'b0;
    end else begin
      freq_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          prog_q <= '0;
          col_q  <= '0;
          if (!empty) begin
            state_q <= ST_TAKE;
            freq_q  <= 1'b1;
          end
        end
        ST_TAKE: begin
          if (abort_i) state_q <= ST_IDLE;
          else if (pix_valid) begin
            addr_q  <= pix_addr_i;
            data_q  <= pix_data;
            state_q <= ST_PUT;
          end
        end
        ST_PUT: begin
          if (abort_i) state_q <= ST_IDLE;
          else if (wr_ack) begin
            if (last_col) begin
              col_q  <= '0;
              prog_q <= prog_q + DIM_W'(1);
              if (last_row) begin
                state_q <= ST_IDLE;
                freq_q  <= regen_i;
              end else begin
                state_q <= ST_TAKE;
              end
            end else begin
              col_q   <= col_q + DIM_W'(1);
              state_q <= ST_TAKE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pix_ready   = (state_q == ST_TAKE);
  assign wr_req      = (state_q == ST_PUT);
  assign wr_addr     = addr_q;
  assign wr_data     = data_q;
  assign frame_req   = freq_q;
  assign busy_o      = busy;
  assign start_o     = start;
  assign line_done_o = line_done;
  assign frame_end_o = (start && empty) || (busy && abort_i) || (line_done && last_row);
  assign col_o       = col_q;
  assign progress_o  = prog_q;

  // R5: an unanswered request keeps its address and data
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack && !abort_i) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
  // R9: abort empties the engine on the next cycle
  a_r9_abort_stop: assert property (@(posedge clk) disable iff (rst)
    (busy && abort_i) |=> (!busy_o && !wr_req));
  // R12: an empty frame never becomes busy
  a_r12_empty_done: assert property (@(posedge clk) disable iff (rst)
    (start && empty) |=> (!busy_o && !frame_req));
  // R4: a real start makes the engine busy and requests a frame
  a_r4_start_req: assert property (@(posedge clk) disable iff (rst)
    (start && !empty) |=> (busy_o && frame_req));
  // R6: progress stays below the height while a frame runs
  a_r6_prog_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (prog_q < height_i));
  // R11: a start during a frame does not clear progress
  a_r11_go_busy: assert property (@(posedge clk) disable iff (rst)
    (go_i && busy && !abort_i) |=> (prog_q >= $past(prog_q)));
endmodule

// File: rtl/wb_frame_seq.sv
module wb_frame_seq
  import wbs_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              pix_ready,
  output logic              wr_req,
  output logic [31:0]       wr_addr,
  output logic [PIX_W-1:0]  wr_data,
  input  logic              wr_ack,
  output logic              frame_req,
  output logic              irq
);
  logic [ADDR_W-1:0] base, pitch, pix_addr;
  logic [DIM_W-1:0]  width, height, col, progress;
  logic              regen, go, abort, busy, start, line_done, frame_end;

  wbs_regs u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_i(busy), .frame_end_i(frame_end), .progress_i(progress),
    .base_o(base), .pitch_o(pitch), .width_o(width), .height_o(height),
    .regen_o(regen), .go_o(go), .abort_o(abort), .irq_o(irq)
  );

  wbs_addr #(.PIX_W(PIX_W)) u_addr (
    .clk(clk), .rst(rst),
    .start_i(start), .line_done_i(line_done),
    .base_i(base), .pitch_i(pitch), .col_i(col),
    .pix_addr_o(pix_addr)
  );

  wbs_engine #(.PIX_W(PIX_W)) u_engine (
    .clk(clk), .rst(rst),
    .go_i(go), .abort_i(abort), .regen_i(regen),
    .width_i(width), .height_i(height), .pix_addr_i(pix_addr),
    .pix_valid(pix_valid), .pix_data(pix_data), .wr_ack(wr_ack),
    .pix_ready(pix_ready), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_req(frame_req), .busy_o(busy), .start_o(start),
    .line_done_o(line_done), .frame_end_o(frame_end),
    .col_o(col), .progress_o(progress)
  );
endmodule

// File: tb/wb_frame_seq_bench.sv
module wb_frame_seq_bench;
  localparam int CLK_NS = 10;
  localparam logic [4:0] A_BASE = 5'h00, A_PITCH = 5'h04, A_DIM = 5'h08,
                         A_CTRL = 5'h0C, A_PROG = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        pix_ready, wr_req, wr_ack = 1'b0, frame_req, irq;
  logic [31:0] wr_addr, wr_data;
  int          n_checks = 0, n_errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  wb_frame_seq u_wb_frame_seq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .frame_req(frame_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int x, input int y);
    return 32'hA500_0000 ^ (32'(y) << 12) ^ 32'(x);
  endfunction

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // sets up and runs one frame; acts as the compositor and the memory sink
  task automatic run_frame(input logic [31:0] base, input logic [31:0] pitch,
                           input int w, input int h, input logic [31:0] ctrl,
                           input int stall, input int poke_at, input logic [31:0] poke_val,
                           input int abort_idx, input bit abort_ack,
                           output int nwr, output int nfr, output bit mid_busy);
    int bx = 0, by = 0, st = 0, it = 0;
    bit aborted = 0;
    logic [31:0] ba, pa;
    ba = base & 32'hFFFF_FFFC;
    pa = pitch & 32'hFFFF_FFF0;
    nwr = 0; nfr = 0; mid_busy = 0;
    bus_write(A_BASE, base);
    bus_write(A_PITCH, pitch);
    bus_write(A_DIM, {16'(h), 16'(w)});
    bus_write(A_CTRL, ctrl);
    forever begin
      nfr += int'(frame_req);
      bus_wr = 1'b0; bus_rd = 1'b0; wr_ack = 1'b0;
      if (it == 1) begin bus_rd = 1'b1; bus_addr = A_CTRL; end
      if (it == 2) mid_busy = bus_rdata[1];
      if (it == poke_at) begin bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = poke_val; end
      if (!wr_req && !pix_ready) break;
      pix_valid = pix_ready;
      pix_data  = pat(bx, by);
      if (wr_req && !aborted) begin
        if (nwr == abort_idx) begin
          aborted = 1;
          bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h0000_4004;
          wr_ack = abort_ack;
          if (abort_ack) nwr++;
        end else if (st >= stall) begin
          chk("R5 addr", wr_addr, ba + 32'(by) * pa + 32'(4 * bx));
          chk("R5 data", wr_data, pat(bx, by));
          wr_ack = 1'b1; st = 0; nwr++;
          if (bx == w - 1) begin bx = 0; by++; end else bx++;
        end else st++;
      end
      it++;
      if (it > 5000) break;
      @(negedge clk);
    end
    bus_wr = 1'b0; bus_rd = 1'b0; pix_valid = 1'b0; wr_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 wr_req", 32'(wr_req), 0);
    chk("R1 frame_req", 32'(frame_req), 0);
    bus_read(A_CTRL, d);  chk("R1 ctrl", d, 32'h5440_0000);
    bus_read(A_BASE, d);  chk("R1 base", d, 0);
    bus_read(A_PITCH, d); chk("R1 pitch", d, 0);
    bus_read(A_DIM, d);   chk("R1 dim", d, 0);
    bus_read(A_PROG, d);  chk("R1 progress", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(A_BASE, 32'h1000_0007);  bus_read(A_BASE, d);  chk("R3 base align", d, 32'h1000_0004);
    bus_write(A_PITCH, 32'h0000_012F); bus_read(A_PITCH, d); chk("R3 pitch align", d, 32'h0000_0120);
    bus_write(A_DIM, 32'h0003_0005);   bus_read(A_DIM, d);   chk("R3 dim", d, 32'h0003_0005);
    bus_write(A_CTRL, 32'hFFE0_8008);  bus_read(A_CTRL, d);  chk("R2 ctrl id", d, 32'h5460_8008);
    bus_write(A_CTRL, 32'h0);          bus_read(A_CTRL, d);  chk("R2 ctrl clear", d, 32'h5440_0000);
  endtask

  task automatic t_basic();
    int nwr, nfr; bit mb; logic [31:0] d;
    run_frame(32'h0000_2000, 32'h40, 4, 3, 32'h5, 0, -1, 0, -1, 0, nwr, nfr, mb);
    chk("R4 busy mid", 32'(mb), 1);
    chk("R4 frame_req", 32'(nfr), 1);
    chk("R5 writes", 32'(nwr), 12);
    bus_read(A_PROG, d); chk("R6 progress", d, 3);
    bus_read(A_CTRL, d); chk("R7 idle", 32'(d[1]), 0);
    chk("R8 irq set", 32'(irq), 1);
  endtask

  task automatic t_noie();
    int nwr, nfr; bit mb;
    bus_write(A_CTRL, 32'h0);
    chk("R8 irq clear", 32'(irq), 0);
    run_frame(32'h0001_0100, 32'h100, 2, 2, 32'h1, 2, -1, 0, -1, 0, nwr, nfr, mb);
    chk("R5 writes stall", 32'(nwr), 4);
    chk("R8 no irq", 32'(irq), 0);
  endtask

  task automatic t_regen();
    int nwr, nfr; bit mb;
    run_frame(32'h0000_4000, 32'h20, 3, 2, 32'h8001, 1, -1, 0, -1, 0, nwr, nfr, mb);
    chk("R13 second frame_req", 32'(nfr), 2);
  endtask

  task automatic t_go_busy();
    int nwr, nfr; bit mb; logic [31:0] d;
    run_frame(32'h0000_8000, 32'h30, 3, 2, 32'h1, 3, 6, 32'h5, -1, 0, nwr, nfr, mb);
    chk("R11 writes", 32'(nwr), 6);
    chk("R11 frame_req", 32'(nfr), 1);
    bus_read(A_PROG, d); chk("R11 progress", d, 2);
    chk("R11 ctrl took ie", 32'(irq), 1);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_pdn();
    int nwr, nfr; bit mb; logic [31:0] d;
    run_frame(32'h0000_9000, 32'h10, 2, 2, 32'h0020_0001, 0, -1, 0, -1, 0, nwr, nfr, mb);
    chk("R10 no writes", 32'(nwr), 0);
    chk("R10 no frame_req", 32'(nfr), 0);
    bus_read(A_PROG, d); chk("R10 progress kept", d, 2);
    bus_read(A_CTRL, d); chk("R10 idle", 32'(d[1]), 0);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_empty();
    int nwr, nfr; bit mb; logic [31:0] d;
    run_frame(32'h0000_A000, 32'h10, 4, 0, 32'h5, 0, -1, 0, -1, 0, nwr, nfr, mb);
    chk("R12 h0 writes", 32'(nwr), 0);
    chk("R12 h0 frame_req", 32'(nfr), 0);
    chk("R12 h0 irq", 32'(irq), 1);
    bus_read(A_PROG, d); chk("R12 progress cleared", d, 0);
    bus_write(A_CTRL, 32'h0);
    run_frame(32'h0000_A000, 32'h10, 0, 3, 32'h1, 0, -1, 0, -1, 0, nwr, nfr, mb);
    chk("R12 w0 writes", 32'(nwr), 0);
  endtask

  task automatic t_abort();
    int nwr, nfr, bad; bit mb; logic [31:0] d;
    run_frame(32'h0000_C000, 32'h20, 3, 3, 32'h8005, 1, -1, 0, 4, 0, nwr, nfr, mb);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wr_req || pix_ready || frame_req) bad++;
    end
    chk("R9 quiet after abort", 32'(bad), 0);
    chk("R9 writes", 32'(nwr), 4);
    chk("R9 frame_req", 32'(nfr), 1);
    bus_read(A_PROG, d); chk("R9 progress", d, 1);
    bus_read(A_CTRL, d); chk("R9 idle", 32'(d[1]), 0);
    chk("R9 irq", 32'(irq), 1);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_abort_last();
    int nwr, nfr; bit mb; logic [31:0] d;
    run_frame(32'h0000_D000, 32'h20, 2, 1, 32'h8005, 0, -1, 0, 1, 1, nwr, nfr, mb);
    chk("R9 same-cycle frame_req", 32'(nfr), 1);
    bus_read(A_PROG, d); chk("R9 same-cycle progress", d, 0);
    bus_read(A_CTRL, d); chk("R9 same-cycle idle", 32'(d[1]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_basic();
    t_noie();
    t_regen();
    t_go_busy();
    t_pdn();
    t_empty();
    t_abort();
    t_abort_last();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule